// File: doc/BRIEF.md
# DMA Engine Control and Status Register

This block is the 32-bit control and status word that each DMA engine carries. Software reads and writes it through a plain memory-mapped port. The descriptor engine core feeds it one-cycle event pulses and its current run state. Software uses the word in four ways:

- It enables the interrupt and the engine.
- It sees which events are pending and clears each by writing a 1 to that bit.
- It sees whether the engine is idle, running or waiting, and whether the engine has waited at some point.
- It requests either a reset of the user logic alone or a reset of the engine together with the user logic.

A reset request stays visible in the word until the engine reports that the reset is complete, and then clears itself.

Engine windows are spaced 0x100 bytes apart. Address decoding is outside the block: the port is already qualified for this engine. Reads are combinational from the stored state. Writes take effect at the next rising clock edge.

Top module: `dcsr_top`

## Requirements
- R1: After reset, and while `rst_n` is low, `rd_data` reads 0 and `irq`, `eng_en`, `user_rst_req` and `full_rst_req` are all 0.
- R2: Bit 0 (interrupt enable) and bit 8 (engine enable) take the written value and read back. `eng_en` follows bit 8.
- R3: A pulse on `ev_pulse[0..4]` sets a flag at bit 2, 3, 4, 5 or 7 respectively. These are descriptor done, alignment error, fetch error, abort and chain end. The flag stays set until it is cleared.
- R4: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Writing 1 to bit 1, or writing the mask 0xBE, clears every flag.
- R5: When an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R6: Bit 1 reads as the OR of the flags. `irq` is high exactly when bit 0 and bit 1 are both set.
- R7: Bits 11:10 report `core_state` (00 idle, 01 running, 10 waiting). They read 00 while a full reset is pending.
- R8: Bit 12 is set when `core_state` enters waiting from another state, and is cleared by writing 1. If entry and clear fall in the same cycle, the bit is set.
- R9: Writing 1 to bit 14 sets bit 14 and `user_rst_req`. Writing 0 has no effect. Both clear at the edge where `user_rst_done` is seen high.
- R10: Writing 1 to bit 15 sets bit 15 and `full_rst_req` and clears bits 0 and 8 and all flags. While the request is pending, those bits stay 0 and events and writes to them are ignored. The request clears at the edge where `full_rst_done` is seen high.
- R11: Bits 6, 9, 13 and 31:16 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this engine's word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current value of the word |
| ev_pulse | input | 5 | Event pulses: done, align, fetch, abort, chain end |
| core_state | input | 2 | Engine core run state |
| user_rst_done | input | 1 | User-logic reset finished |
| full_rst_done | input | 1 | Engine and user reset finished |
| irq | output | 1 | Interrupt request |
| eng_en | output | 1 | Engine enable |
| user_rst_req | output | 1 | User-logic reset request |
| full_rst_req | output | 1 | Full reset request |

## Verification
Three same-cycle collisions matter:

- An event pulse and software's write-1 clear of the same flag.
- Entry into the waiting state and the clear of the waited bit.
- A full reset request and events or enable writes that arrive while it is pending.

The vector table places each pair in one cycle: a write with the clear bit set goes out together with the event pulse, or the state input steps to waiting together with the clear. Each case is judged by the read word after that edge, where the flag must still be set, or, under a full reset, the enables and flags must still be zero.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
    localparam int CSR_W   = 32;
    localparam int NUM_EV  = 5;
    localparam int B_IE    = 0;
    localparam int B_ACT   = 1;
    localparam int B_EN    = 8;
    localparam int B_ST_LO = 10;
    localparam int B_WAITD = 12;
    localparam int B_URST  = 14;
    localparam int B_FRST  = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_WAIT = 2'b10
    } eng_state_e;

    // Word position of event i; bit 6 is skipped.
    function automatic int ev_pos(input int i);
        return (i >= 4) ? i + 3 : i + 2;
    endfunction
endpackage

// File: rtl/dcsr_evt_bank.sv
module dcsr_evt_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr_i)
                st_d.flags[i] = 1'b0;
            else
                st_d.flags[i] = set_i[i] | (st_q.flags[i] & ~ack_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R5: an event pulse wins over a same-cycle clear
        p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[g] && !clr_i) |=> flags_o[g]);
        // R3: a flag holds until it is cleared
        p_flag_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !ack_i[g] && !clr_i) |=> flags_o[g]);
    end
endmodule

// File: rtl/dcsr_rst_hs.sv
module dcsr_rst_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic req_o
);
    typedef struct packed {
        logic req;
    } hs_s;

    hs_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req) st_d.req = ~done_i;
        else          st_d.req = start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R9/R10: a request holds until done, then drops
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !done_i) |=> req_o);
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && done_i) |=> !req_o);
endmodule

// File: rtl/dcsr_top.sv
module dcsr_top
    import dcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CSR_W-1:0]    wr_data,
    output logic [CSR_W-1:0]    rd_data,
    input  logic [NUM_EV-1:0]   ev_pulse,
    input  logic [1:0]          core_state,
    input  logic                user_rst_done,
    input  logic                full_rst_done,
    output logic                irq,
    output logic                eng_en,
    output logic                user_rst_req,
    output logic                full_rst_req
);
    typedef struct packed {
        logic       ie;
        logic       en;
        logic       waited;
        logic [1:0] prev_st;
    } ctl_s;

    ctl_s st_d, st_q;

    logic [NUM_EV-1:0] flags;
    logic [NUM_EV-1:0] ack;
    logic              clr_all;
    logic              any_ev;
    logic              ack_all;
    logic              enter_wait;

    assign clr_all = full_rst_req | (wr_en & wr_data[B_FRST]);
    assign ack_all = wr_en & wr_data[B_ACT];

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ack
        localparam int POS = ev_pos(g);
        assign ack[g] = ack_all | (wr_en & wr_data[POS]);
    end

    dcsr_evt_bank #(.N(NUM_EV)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_pulse),
        .ack_i   (ack),
        .clr_i   (clr_all),
        .flags_o (flags)
    );

    dcsr_rst_hs u_urst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_en & wr_data[B_URST]),
        .done_i  (user_rst_done),
        .req_o   (user_rst_req)
    );

    dcsr_rst_hs u_frst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_en & wr_data[B_FRST]),
        .done_i  (full_rst_done),
        .req_o   (full_rst_req)
    );

    assign enter_wait = (core_state == ST_WAIT) && (st_q.prev_st != ST_WAIT);

    always_comb begin
        st_d         = st_q;
        st_d.prev_st = core_state;
        if (wr_en) begin
            st_d.ie = wr_data[B_IE];
            st_d.en = wr_data[B_EN];
        end
        if (clr_all) begin
            st_d.ie = 1'b0;
            st_d.en = 1'b0;
        end
        st_d.waited = enter_wait |
                      (st_q.waited & ~(wr_en & wr_data[B_WAITD]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_ev = |flags;
    assign irq    = st_q.ie & any_ev;
    assign eng_en = st_q.en;

    always_comb begin
        rd_data = '0;
        rd_data[B_IE]    = st_q.ie;
        rd_data[B_ACT]   = any_ev;
        for (int i = 0; i < NUM_EV; i++)
            rd_data[ev_pos(i)] = flags[i];
        rd_data[B_EN]    = st_q.en;
        rd_data[B_ST_LO +: 2] = full_rst_req ? ST_IDLE : core_state;
        rd_data[B_WAITD] = st_q.waited;
        rd_data[B_URST]  = user_rst_req;
        rd_data[B_FRST]  = full_rst_req;
    end

    // R10: pending full reset keeps engine and interrupt off
    p_full_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_req |-> (!eng_en && !irq));
    // R2: a plain write sets the engine enable
    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[B_FRST] && !full_rst_req) |=> (eng_en == $past(wr_data[B_EN])));
    // R8: entering waiting sets the sticky bit
    p_waited_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enter_wait |=> rd_data[B_WAITD]);
    // R6: interrupt only with enable
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[B_IE] && rd_data[B_ACT]));
endmodule

// File: tb/sim_dcsr_top.sv
`timescale 1ns/1ps
module sim_dcsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  ev_pulse = '0;
    logic [1:0]  core_state = 2'b00;
    logic        user_rst_done = 1'b0;
    logic        full_rst_done = 1'b0;
    logic        irq, eng_en, user_rst_req, full_rst_req;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dcsr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_pulse(ev_pulse), .core_state(core_state),
        .user_rst_done(user_rst_done), .full_rst_done(full_rst_done),
        .irq(irq), .eng_en(eng_en), .user_rst_req(user_rst_req),
        .full_rst_req(full_rst_req)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] wd;
        logic [4:0]  ev;
        logic [1:0]  cs;
        logic        ud;
        logic        fd;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_ureq;
        logic        exp_freq;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h0000_0101, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0101, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 32'h0,         5'b00001, 2'b00, 1'b0, 1'b0, 32'h0000_0107, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 R6
        '{1'b0, 32'h0,         5'b10000, 2'b00, 1'b0, 1'b0, 32'h0000_0187, 1'b1, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b1, 32'h0000_0105, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0183, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 single clear
        '{1'b1, 32'h0000_0101, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0183, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 zero no effect
        '{1'b1, 32'h0000_0180, 5'b10000, 2'b00, 1'b0, 1'b0, 32'h0000_0182, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 R6
        '{1'b0, 32'h0,         5'b01110, 2'b00, 1'b0, 1'b0, 32'h0000_01BA, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b1, 32'h0000_0102, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 bit1
        '{1'b0, 32'h0,         5'b11111, 2'b00, 1'b0, 1'b0, 32'h0000_01BE, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b1, 32'h0000_01BE, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 mask
        '{1'b0, 32'h0,         5'b00000, 2'b01, 1'b0, 1'b0, 32'h0000_0500, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
        '{1'b0, 32'h0,         5'b00000, 2'b10, 1'b0, 1'b0, 32'h0000_1900, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 R7
        '{1'b1, 32'h0000_1100, 5'b00000, 2'b10, 1'b0, 1'b0, 32'h0000_0900, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 clear
        '{1'b1, 32'h0000_4100, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_4100, 1'b0, 1'b1, 1'b0, 8'd9},  // R9
        '{1'b1, 32'h0000_0100, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_4100, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 zero
        '{1'b0, 32'h0,         5'b00000, 2'b00, 1'b1, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 done
        '{1'b1, 32'h0000_8101, 5'b00001, 2'b00, 1'b0, 1'b0, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 8'd10}, // R10
        '{1'b1, 32'h0000_0101, 5'b00100, 2'b01, 1'b0, 1'b0, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 R7
        '{1'b0, 32'h0,         5'b00000, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 done
        '{1'b1, 32'hFFFF_2240, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 8'd11}, // R11
        '{1'b1, 32'h0000_1000, 5'b00000, 2'b10, 1'b0, 1'b0, 32'h0000_1800, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 same cycle
        '{1'b1, 32'h0000_1000, 5'b00000, 2'b00, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 8'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [31:0] erd,
                              input logic eirq, input logic eu, input logic ef);
        check(req, rd_data, erd);
        check(req, {28'd0, irq, eng_en, user_rst_req, full_rst_req},
                   {28'd0, eirq, erd[8], eu, ef});
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R1", 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1", 32'h0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr_en         = TBL[i].we;
            wr_data       = TBL[i].wd;
            ev_pulse      = TBL[i].ev;
            core_state    = TBL[i].cs;
            user_rst_done = TBL[i].ud;
            full_rst_done = TBL[i].fd;
            @(posedge clk);
            #1;
            check_outs($sformatf("R%0d row%0d", TBL[i].tag, i),
                       TBL[i].exp_rd, TBL[i].exp_irq, TBL[i].exp_ureq, TBL[i].exp_freq);
            @(negedge clk);
        end
        wr_en = 1'b0; ev_pulse = '0; user_rst_done = 1'b0; full_rst_done = 1'b0;

        // R1: reset in mid-run clears enables, flags and requests
        wr_en = 1'b1; wr_data = 32'h0000_4101; ev_pulse = 5'b00010;
        @(negedge clk);
        wr_en = 1'b0; ev_pulse = '0;
        check_outs("R1 pre", 32'h0000_410B, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check_outs("R1 async", 32'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 after", 32'h0, 1'b0, 1'b0, 1'b0);

        // R9: done without a pending request is ignored
        user_rst_done = 1'b1;
        @(negedge clk);
        user_rst_done = 1'b0;
        check_outs("R9 stray done", 32'h0, 1'b0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule